// File: doc/BRIEF.md
# Programmed I/O Bus Sequencer

This block carries out the word-at-a-time I/O instructions of a small 16-bit processor on a bus shared by many peripheral devices. The core hands it a decoded instruction word and the current accumulator with a one-cycle `start`. The block then drives the 10-bit device address, which holds a 4-bit function code and a 6-bit device code. It drives the 16-bit output bus where the instruction calls for it and tests the device-ready line once. When the device is ready, and the instruction needs a handshake, it issues one single-cycle strobe. It finishes with `done`, a new accumulator value and a skip flag for the program counter.

The block never waits for a slow device. It samples ready exactly once, and a ready device is reported by skipping the next instruction. A program can therefore poll several devices in a tight loop. Five instruction kinds are handled. Input loads or merges the input bus into the accumulator. Output presents the accumulator on the output bus. Sense reports readiness only. Control pulse and set mask both act without a ready test.

Top module: `pio_bus_seq`

## Requirements
- R1: While busy, `addr_bus[9:6]` carries instruction bits `instr[9:6]` (function code) and `addr_bus[5:0]` carries `instr[5:0]` (device code). The value is held constant from the cycle after `start` is taken until `done`. `addr_bus` is zero when idle.
- R2: The opcode is `instr[15:10]`. Octal 54 is input, 34 is sense, 14 is control pulse, and 74 is output. Octal 74 is set mask instead when the device code equals parameter `MASK_DEV` (default octal 20).
- R3: Input with ready high and `instr[9]`=1 replaces the accumulator with `in_bus`: `acc_out`=`in_bus`, `acc_we`=1, `skip`=1, and one `ack_strobe`.
- R4: Input with ready high and `instr[9]`=0 ORs `in_bus` into the accumulator, with `acc_we`=1, `skip`=1 and one `ack_strobe`.
- R5: Output drives `out_bus` with the accumulator while busy. With ready high it issues one `ack_strobe` and sets `skip`. `out_bus` is zero unless an output or set-mask instruction is in flight.
- R6: Sense with ready high sets `skip` and issues no strobe.
- R7: For input, output and sense with ready low, there is no strobe, no `acc_we` and no skip, and `acc_out` equals the accumulator given at `start`.
- R8: Control pulse emits one `ctl_pulse` whatever the ready line says, and never skips.
- R9: Set mask drives `out_bus` with the accumulator and emits one `mask_pulse` whatever the ready line says, and never skips.
- R10: `start` is taken at clock edge k. Ready is sampled at edge k+2. A strobe, when there is one, is high for exactly the cycle after edge k+2, and `done` is high for the cycle after edge k+3. Without a strobe, `done` is high for the cycle after edge k+2. At most one strobe is high at any time.
- R11: Any other opcode gives `done` and `illegal` for the cycle after edge k. There is no strobe, no skip, no `acc_we`, and `addr_bus` stays zero.
- R12: `start` is ignored while `busy` is high.
- R13: `master_clear` is high after every clock edge at which `rst` is high, and low after an edge at which `rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (taken when idle) |
| instr | input | 16 | Instruction word, bit 15 is the leftmost bit |
| acc_in | input | DATA_W | Accumulator value at start |
| dev_ready | input | 1 | Ready line from the addressed device |
| in_bus | input | DATA_W | Input data bus from devices |
| addr_bus | output | 10 | Function code and device code |
| out_bus | output | DATA_W | Output data bus to devices |
| ack_strobe | output | 1 | Transfer strobe, resets the device ready flag |
| ctl_pulse | output | 1 | Output control pulse |
| mask_pulse | output | 1 | Mask-set pulse |
| master_clear | output | 1 | Clear line to all devices |
| acc_out | output | DATA_W | Resulting accumulator value, valid with done |
| acc_we | output | 1 | Write enable for acc_out, with done |
| skip | output | 1 | Skip next instruction, with done |
| done | output | 1 | Instruction finished |
| illegal | output | 1 | Opcode outside the I/O set, with done |
| busy | output | 1 | Instruction in flight |

## Verification
A wrong sequencer state shows within one to four cycles of `start`. `done` or the strobe lands in the wrong cycle, a strobe appears for a not-ready device, or a second instruction is taken mid-flight. A corrupted latched command shows at once as a moving or wrong address bus, or as the accumulator on `out_bus` for an input. A wrong ready sample or merge path shows at `done` as a wrong skip, `acc_we` or `acc_out`. The directed scenarios cover every class with ready high and low, both input load modes, the mask device code and an illegal opcode.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int INSTR_W = 16;
    localparam int OPC_W   = 6;
    localparam int FN_W    = 4;
    localparam int DEV_W   = 6;
    localparam int ADDR_W  = FN_W + DEV_W;

    localparam logic [OPC_W-1:0] OPC_IN    = 6'o54;
    localparam logic [OPC_W-1:0] OPC_OUT   = 6'o74;
    localparam logic [OPC_W-1:0] OPC_SENSE = 6'o34;
    localparam logic [OPC_W-1:0] OPC_CTL   = 6'o14;

    typedef enum logic [2:0] {
        CLS_NONE, CLS_IN, CLS_OUT, CLS_SENSE, CLS_CTL, CLS_MASK
    } io_class_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_SAMPLE, ST_STROBE, ST_FINISH
    } seq_state_e;

    typedef struct packed {
        io_class_e         cls;
        logic              load_mode;
        logic [ADDR_W-1:0] addr;
    } io_cmd_t;

    // Classes whose outcome depends on the ready line
    function automatic logic needs_ready(io_class_e c);
        return (c == CLS_IN) || (c == CLS_OUT) || (c == CLS_SENSE);
    endfunction

    // Classes that emit a strobe once allowed to proceed
    function automatic logic has_strobe(io_class_e c);
        return (c != CLS_SENSE) && (c != CLS_NONE);
    endfunction

    // Classes that drive the accumulator onto the output bus
    function automatic logic drives_out(io_class_e c);
        return (c == CLS_OUT) || (c == CLS_MASK);
    endfunction

endpackage

// File: rtl/pio_decode.sv
module pio_decode
    import pio_pkg::*;
#(
    parameter logic [DEV_W-1:0] MASK_DEV = 6'o20
) (
    input  logic [INSTR_W-1:0] instr,
    output io_cmd_t            cmd,
    output logic               legal
);
    logic [OPC_W-1:0] opc;
    logic [DEV_W-1:0] dev;
    io_class_e        cls;

    assign opc = instr[INSTR_W-1 -: OPC_W];
    assign dev = instr[DEV_W-1:0];

    always_comb begin
        unique case (opc)
            OPC_IN:    cls = CLS_IN;
            OPC_OUT:   cls = (dev == MASK_DEV) ? CLS_MASK : CLS_OUT;
            OPC_SENSE: cls = CLS_SENSE;
            OPC_CTL:   cls = CLS_CTL;
            default:   cls = CLS_NONE;
        endcase
    end

    assign legal         = (cls != CLS_NONE);
    assign cmd.cls       = cls;
    assign cmd.load_mode = instr[ADDR_W-1];
    // An illegal word leaves the address bus untouched (zero)
    assign cmd.addr      = legal ? instr[ADDR_W-1:0] : '0;

endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
    import pio_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      legal,
    input  io_class_e cls,
    input  logic      dev_ready,
    output logic      accept,
    output logic      busy,
    output logic      done,
    output logic      skip,
    output logic      illegal,
    output logic      ack_strobe,
    output logic      ctl_pulse,
    output logic      mask_pulse,
    output logic      acc_we,
    output logic      load_en
);
    seq_state_e state_q, state_d;
    logic       pass_q, pass_d;
    logic       ill_q, ill_d;
    logic       pass_now;

    assign accept   = (state_q == ST_IDLE) && start;
    assign pass_now = !needs_ready(cls) || dev_ready;

    always_comb begin
        state_d = state_q;
        pass_d  = pass_q;
        ill_d   = ill_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    pass_d  = 1'b0;
                    ill_d   = !legal;
                    state_d = legal ? ST_ADDR : ST_FINISH;
                end
            end
            ST_ADDR:   state_d = ST_SAMPLE;
            ST_SAMPLE: begin
                pass_d  = pass_now;
                state_d = (pass_now && has_strobe(cls)) ? ST_STROBE : ST_FINISH;
            end
            ST_STROBE: state_d = ST_FINISH;
            ST_FINISH: begin
                ill_d   = 1'b0;
                state_d = ST_IDLE;
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pass_q  <= 1'b0;
            ill_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pass_q  <= pass_d;
            ill_q   <= ill_d;
        end
    end

    logic in_strobe;
    assign in_strobe  = (state_q == ST_STROBE);
    assign busy       = (state_q != ST_IDLE);
    assign done       = (state_q == ST_FINISH);
    assign illegal    = done && ill_q;
    assign skip       = done && !ill_q && pass_q && needs_ready(cls);
    assign acc_we     = done && !ill_q && pass_q && (cls == CLS_IN);
    assign ack_strobe = in_strobe && ((cls == CLS_IN) || (cls == CLS_OUT));
    assign ctl_pulse  = in_strobe && (cls == CLS_CTL);
    assign mask_pulse = in_strobe && (cls == CLS_MASK);
    assign load_en    = in_strobe && (cls == CLS_IN);

    // R10: never more than one strobe line at once
    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ack_strobe, ctl_pulse, mask_pulse}));
    // R10: completion follows every strobe by one cycle
    assert_done_after_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        (ack_strobe || ctl_pulse || mask_pulse) |=> done);
    // R11: an illegal word writes nothing and never skips
    assert_illegal_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!acc_we && !skip));
    // R6: skip only ever appears on completion
    assert_skip_with_done_R6: assert property (@(posedge clk) disable iff (rst)
        skip |-> done);
    // R8: control pulse never skips
    assert_ctl_no_skip_R8: assert property (@(posedge clk) disable iff (rst)
        ctl_pulse |=> !skip);
    // R9: set mask never skips
    assert_mask_no_skip_R9: assert property (@(posedge clk) disable iff (rst)
        mask_pulse |=> !skip);
    // R12: a new command is taken only from idle
    assert_no_restart_R12: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
    import pio_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  io_cmd_t           cmd_in,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] in_bus,
    input  logic              load_en,
    input  logic              busy,
    output io_cmd_t           cmd_q,
    output logic [ADDR_W-1:0] addr_bus,
    output logic [DATA_W-1:0] out_bus,
    output logic [DATA_W-1:0] acc_out
);
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] merged;

    // Load mode replaces the accumulator, otherwise the bus is ORed in
    assign merged = cmd_q.load_mode ? in_bus : (acc_q | in_bus);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '{cls: CLS_NONE, load_mode: 1'b0, addr: '0};
            acc_q <= '0;
        end else if (accept) begin
            cmd_q <= cmd_in;
            acc_q <= acc_in;
        end else if (load_en) begin
            acc_q <= merged;
        end
    end

    assign addr_bus = busy ? cmd_q.addr : '0;
    assign out_bus  = (busy && drives_out(cmd_q.cls)) ? acc_q : '0;
    assign acc_out  = acc_q;

    // R1: address is held for the whole instruction
    assert_addr_stable_R1: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(addr_bus));
    // R5: output bus is quiet when idle
    assert_out_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (out_bus == '0));

endmodule

// File: rtl/pio_bus_seq.sv
module pio_bus_seq
    import pio_pkg::*;
#(
    parameter int               DATA_W   = 16,
    parameter logic [DEV_W-1:0] MASK_DEV = 6'o20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  acc_in,
    input  logic               dev_ready,
    input  logic [DATA_W-1:0]  in_bus,
    output logic [ADDR_W-1:0]  addr_bus,
    output logic [DATA_W-1:0]  out_bus,
    output logic               ack_strobe,
    output logic               ctl_pulse,
    output logic               mask_pulse,
    output logic               master_clear,
    output logic [DATA_W-1:0]  acc_out,
    output logic               acc_we,
    output logic               skip,
    output logic               done,
    output logic               illegal,
    output logic               busy
);
    io_cmd_t cmd_dec, cmd_q;
    logic    legal, accept, load_en;

    pio_decode #(.MASK_DEV(MASK_DEV)) u_decode (
        .instr (instr),
        .cmd   (cmd_dec),
        .legal (legal)
    );

    pio_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .legal      (legal),
        .cls        (cmd_q.cls),
        .dev_ready  (dev_ready),
        .accept     (accept),
        .busy       (busy),
        .done       (done),
        .skip       (skip),
        .illegal    (illegal),
        .ack_strobe (ack_strobe),
        .ctl_pulse  (ctl_pulse),
        .mask_pulse (mask_pulse),
        .acc_we     (acc_we),
        .load_en    (load_en)
    );

    pio_datapath #(.DATA_W(DATA_W)) u_data (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .cmd_in   (cmd_dec),
        .acc_in   (acc_in),
        .in_bus   (in_bus),
        .load_en  (load_en),
        .busy     (busy),
        .cmd_q    (cmd_q),
        .addr_bus (addr_bus),
        .out_bus  (out_bus),
        .acc_out  (acc_out)
    );

    logic mclr_q;
    always_ff @(posedge clk) mclr_q <= rst;
    assign master_clear = mclr_q;

    // R13: devices see the clear line after a reset edge
    assert_mclr_R13: assert property (@(posedge clk) rst |=> master_clear);

endmodule

// File: tb/pio_bus_seq_bench.sv
module pio_bus_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] acc_in = '0;
    logic        dev_ready = 1'b0;
    logic [15:0] in_bus = '0;
    logic [9:0]  addr_bus;
    logic [15:0] out_bus, acc_out;
    logic        ack_strobe, ctl_pulse, mask_pulse, master_clear;
    logic        acc_we, skip, done, illegal, busy;

    always #10 clk = ~clk;  // 50 MHz

    pio_bus_seq u_pio_bus_seq (
        .clk(clk), .rst(rst), .start(start), .instr(instr), .acc_in(acc_in),
        .dev_ready(dev_ready), .in_bus(in_bus), .addr_bus(addr_bus),
        .out_bus(out_bus), .ack_strobe(ack_strobe), .ctl_pulse(ctl_pulse),
        .mask_pulse(mask_pulse), .master_clear(master_clear), .acc_out(acc_out),
        .acc_we(acc_we), .skip(skip), .done(done), .illegal(illegal), .busy(busy)
    );

    int n_checks = 0;
    int n_fails  = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Observations of one instruction
    logic [9:0]  o_addr;
    logic [15:0] o_out;
    logic        o_addr_moved;
    int          o_ack, o_ctl, o_mask, o_strobe_cyc, o_done_cyc;
    logic        o_skip, o_we, o_ill;
    logic [15:0] o_acc;

    // Start edge is k; observation c is taken in the cycle after edge k+c-1
    task automatic run(input logic [15:0] ins, input logic [15:0] acc,
                       input logic rdy, input logic [15:0] inb, input bit poke);
        @(negedge clk);
        instr = ins; acc_in = acc; dev_ready = rdy; in_bus = inb; start = 1'b1;
        o_ack = 0; o_ctl = 0; o_mask = 0; o_strobe_cyc = 0; o_done_cyc = 0;
        o_addr_moved = 1'b0; o_skip = 0; o_we = 0; o_ill = 0; o_acc = '0;
        for (int c = 1; c <= 8; c++) begin
            @(negedge clk);
            if (c == 1) begin
                start = poke;
                if (poke) instr = 16'o14_0_77 | 16'o070000;
                o_addr = addr_bus;
                o_out  = out_bus;
            end
            if (c == 3) start = 1'b0;
            if (busy && addr_bus !== o_addr) o_addr_moved = 1'b1;
            if (ack_strobe) begin o_ack++;  o_strobe_cyc = c; end
            if (ctl_pulse)  begin o_ctl++;  o_strobe_cyc = c; end
            if (mask_pulse) begin o_mask++; o_strobe_cyc = c; end
            if (done && o_done_cyc == 0) begin
                o_done_cyc = c; o_skip = skip; o_we = acc_we;
                o_ill = illegal; o_acc = acc_out;
            end
        end
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R13", "master_clear in reset", master_clear, 1);
        chk("R1", "idle addr", addr_bus, 0);
        chk("R5", "idle out_bus", out_bus, 0);
        chk("R10", "idle strobes", {ack_strobe, ctl_pulse, mask_pulse, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R13", "master_clear after reset", master_clear, 0);
        chk("R12", "busy after reset", busy, 0);
    endtask

    task automatic t_in_load();
        run({6'o54, 4'b1011, 6'o07}, 16'hF0F0, 1'b1, 16'h1234, 0);
        chk("R1", "input addr", o_addr, {4'b1011, 6'o07});
        chk("R1", "addr moved", o_addr_moved, 0);
        chk("R3", "ack count", o_ack, 1);
        chk("R10", "strobe cycle", o_strobe_cyc, 3);
        chk("R10", "done cycle", o_done_cyc, 4);
        chk("R3", "acc_out", o_acc, 16'h1234);
        chk("R3", "we/skip", {o_we, o_skip}, 2'b11);
        chk("R5", "out_bus quiet on input", o_out, 0);
    endtask

    task automatic t_in_or();
        run({6'o54, 4'b0010, 6'o12}, 16'h00F0, 1'b1, 16'h0F01, 0);
        chk("R4", "acc_out merged", o_acc, 16'h0FF1);
        chk("R4", "we/skip", {o_we, o_skip}, 2'b11);
        chk("R4", "ack count", o_ack, 1);
    endtask

    task automatic t_in_notready();
        run({6'o54, 4'b1000, 6'o03}, 16'h5555, 1'b0, 16'hFFFF, 0);
        chk("R7", "no strobe", o_ack + o_ctl + o_mask, 0);
        chk("R10", "done cycle no strobe", o_done_cyc, 3);
        chk("R7", "we/skip", {o_we, o_skip}, 2'b00);
        chk("R7", "acc unchanged", o_acc, 16'h5555);
    endtask

    task automatic t_out();
        run({6'o74, 4'b0001, 6'o05}, 16'hA5C3, 1'b1, 16'h0, 0);
        chk("R5", "out_bus", o_out, 16'hA5C3);
        chk("R5", "ack count", o_ack, 1);
        chk("R5", "skip", o_skip, 1);
        chk("R5", "no acc write", o_we, 0);
        chk("R10", "done cycle", o_done_cyc, 4);
        run({6'o74, 4'b0001, 6'o05}, 16'h3C3C, 1'b0, 16'h0, 0);
        chk("R7", "output not ready strobes", o_ack, 0);
        chk("R7", "output not ready skip", o_skip, 0);
    endtask

    task automatic t_sense();
        run({6'o34, 4'b0100, 6'o11}, 16'h0001, 1'b1, 16'h0, 0);
        chk("R6", "sense skip", o_skip, 1);
        chk("R6", "sense no strobe", o_ack + o_ctl + o_mask, 0);
        chk("R6", "sense done cycle", o_done_cyc, 3);
        run({6'o34, 4'b0100, 6'o11}, 16'h0001, 1'b0, 16'h0, 0);
        chk("R7", "sense not ready skip", o_skip, 0);
    endtask

    task automatic t_ctl();
        run({6'o14, 4'b0110, 6'o21}, 16'h7777, 1'b0, 16'h0, 0);
        chk("R8", "ctl pulse count", o_ctl, 1);
        chk("R8", "ctl strobe cycle", o_strobe_cyc, 3);
        chk("R8", "ctl skip", o_skip, 0);
        chk("R2", "ctl addr", o_addr, {4'b0110, 6'o21});
        chk("R5", "ctl out_bus quiet", o_out, 0);
    endtask

    task automatic t_mask();
        run({6'o74, 4'b0000, 6'o20}, 16'hBEEF, 1'b0, 16'h0, 0);
        chk("R9", "mask pulse count", o_mask, 1);
        chk("R2", "mask not ack", o_ack, 0);
        chk("R9", "mask out_bus", o_out, 16'hBEEF);
        chk("R9", "mask skip", o_skip, 0);
        run({6'o74, 4'b0000, 6'o20}, 16'h1111, 1'b1, 16'h0, 0);
        chk("R9", "mask ready no skip", o_skip, 0);
        chk("R9", "mask ready pulse", o_mask, 1);
    endtask

    task automatic t_illegal();
        run({6'o02, 4'b1111, 6'o77}, 16'h2222, 1'b1, 16'hFFFF, 0);
        chk("R11", "illegal flag", o_ill, 1);
        chk("R11", "illegal done cycle", o_done_cyc, 1);
        chk("R11", "illegal addr", o_addr, 0);
        chk("R11", "illegal strobes", o_ack + o_ctl + o_mask, 0);
        chk("R11", "illegal we/skip", {o_we, o_skip}, 2'b00);
    endtask

    task automatic t_busy_start();
        run({6'o54, 4'b1001, 6'o04}, 16'h0, 1'b1, 16'hCAFE, 1);
        chk("R12", "no ctl pulse from busy start", o_ctl, 0);
        chk("R12", "addr kept", o_addr_moved, 0);
        chk("R12", "first instr result", o_acc, 16'hCAFE);
        chk("R12", "single ack", o_ack, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_in_load();
        t_in_or();
        t_in_notready();
        t_out();
        t_sense();
        t_ctl();
        t_mask();
        t_illegal();
        t_busy_start();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule